// File: doc/BRIEF.md
# Sink Presence Deglitch Filter

This block cleans up two asynchronous sink-presence signals, hot-plug detect and receiver-sense, inside the control clock domain. Each raw input is brought in through a two-flop synchronizer. It then passes through two counting stages in series. The first stage is a short glitch rejector with a 4-bit width N. The second is a coarse stability qualifier with a 12-bit width M, counted in units of 1024 clocks.

The two filtered levels are presented together as a 2-bit status word for readback. Each level also drives a one-clock rise event and a one-clock fall event, meant as interrupt sources. The width fields come from static configuration registers. Each input has its own pair of fields, set apart from the other input's pair.

Top module: `presence_deglitch`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `filt_status` is 2'b00 and all four event outputs are 0.
- R2: With glitch width N and valid width M held constant, a raw level change that persists long enough appears on the filtered level at the (4+N+M*1024)-th rising clock edge after the raw input changes.
- R3: A raw pulse lasting N clock cycles or fewer, where N is the glitch width, never changes the filtered level. With M=0, a pulse of N+1 cycles is accepted.
- R4: With N=0, a raw pulse lasting M*1024 cycles or fewer never changes the filtered level. A pulse of M*1024+1 cycles is accepted.
- R5: Any cycle in which the raw level, after synchronization, equals the stage's current output restarts that stage's count. For example, two pulses of N cycles separated by a one-cycle gap are rejected.
- R6: A rise event is a single-cycle pulse. It is high exactly in the first cycle in which the filtered level reads 1. Rise and fall are never high together.
- R7: A fall event is a single-cycle pulse. It is high exactly in the first cycle in which the filtered level reads 0 after having been 1.
- R8: Hot-plug and receiver-sense are filtered independently, each with its own glitch and valid width. The same raw stimulus can therefore be accepted on one channel and rejected on the other.
- R9: `filt_status[0]` carries the filtered hot-plug level and `filt_status[1]` carries the filtered receiver-sense level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_raw | input | 1 | Asynchronous hot-plug detect input |
| rxs_raw | input | 1 | Asynchronous receiver-sense input |
| hpd_glitch_w | input | 4 | Hot-plug glitch width N |
| hpd_valid_w | input | 12 | Hot-plug valid width M (units of 1024 clocks) |
| rxs_glitch_w | input | 4 | Receiver-sense glitch width N |
| rxs_valid_w | input | 12 | Receiver-sense valid width M |
| filt_status | output | 2 | Filtered levels: bit 0 hot-plug, bit 1 receiver-sense |
| hpd_rise | output | 1 | One-cycle pulse on filtered hot-plug rising |
| hpd_fall | output | 1 | One-cycle pulse on filtered hot-plug falling |
| rxs_rise | output | 1 | One-cycle pulse on filtered receiver-sense rising |
| rxs_fall | output | 1 | One-cycle pulse on filtered receiver-sense falling |

## Verification
The assertions accept any raw input pattern. They do assume the width fields are static: a stage's output may move only after a full mismatch count against the limit currently applied. A width change in the middle of a count would make that count end early or late. The stimulus therefore rewrites the width fields only while both raw inputs are low and both filtered levels have settled at 0. Raw inputs are driven on falling edges, so the synchronizer always captures a settled value.

// File: rtl/hpd_filt_pkg.sv
package hpd_filt_pkg;
    localparam int GLITCH_W = 4;
    localparam int VALID_W  = 12;
    localparam int SCALE_SH = 10;
    localparam int STAB_W   = VALID_W + SCALE_SH;
    localparam int NUM_CH   = 2;
    localparam int CH_HPD   = 0;
    localparam int CH_RXS   = 1;

    typedef struct packed {
        logic [GLITCH_W-1:0] glitch;
        logic [VALID_W-1:0]  valid;
    } chan_cfg_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } chan_out_t;

    function automatic logic [STAB_W-1:0] stab_limit(input logic [VALID_W-1:0] m);
        return {m, {SCALE_SH{1'b0}}};
    endfunction
endpackage

// File: rtl/dgf_sync.sv
module dgf_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dgf_count_stage.sv
module dgf_count_stage #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [CNT_W-1:0] limit,
    output logic             dout
);
    logic [CNT_W-1:0] cnt;
    logic             mismatch;
    logic             reached;

    assign mismatch = (din != dout);
    assign reached  = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            dout <= 1'b0;
        end else if (!mismatch) begin
            cnt <= '0;
        end else if (reached) begin
            cnt  <= '0;
            dout <= din;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_HOLD_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (din == dout) |=> $stable(dout)) else $error("hold on match"); // R5
    AST_HOLD_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (din != dout && cnt < limit) |=> $stable(dout)) else $error("early flip"); // R3
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (din == dout) |=> (cnt == '0)) else $error("count not restarted"); // R5
endmodule

// File: rtl/dgf_channel.sv
module dgf_channel
    import hpd_filt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    input  chan_cfg_t cfg,
    output chan_out_t out
);
    logic synced;
    logic deglitched;
    logic level;
    logic level_d;

    dgf_sync u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    dgf_count_stage #(.CNT_W(GLITCH_W)) u_glitch (
        .clk   (clk),
        .rst   (rst),
        .din   (synced),
        .limit (cfg.glitch),
        .dout  (deglitched)
    );

    dgf_count_stage #(.CNT_W(STAB_W)) u_stable (
        .clk   (clk),
        .rst   (rst),
        .din   (deglitched),
        .limit (stab_limit(cfg.valid)),
        .dout  (level)
    );

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b0;
        else     level_d <= level;
    end

    assign out.level = level;
    assign out.rise  = level & ~level_d;
    assign out.fall  = ~level & level_d;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(out.rise && out.fall)) else $error("rise and fall together"); // R6
    AST_RISE_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        out.rise |=> !out.rise) else $error("rise longer than one cycle"); // R6
    AST_RISE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |-> out.rise) else $error("missed rise"); // R6
    AST_FALL_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $fell(level) |-> out.fall) else $error("missed fall"); // R7
    AST_FALL_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        out.fall |=> !out.fall) else $error("fall longer than one cycle"); // R7
endmodule

// File: rtl/presence_deglitch.sv
module presence_deglitch
    import hpd_filt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hpd_raw,
    input  logic                rxs_raw,
    input  logic [GLITCH_W-1:0] hpd_glitch_w,
    input  logic [VALID_W-1:0]  hpd_valid_w,
    input  logic [GLITCH_W-1:0] rxs_glitch_w,
    input  logic [VALID_W-1:0]  rxs_valid_w,
    output logic [NUM_CH-1:0]   filt_status,
    output logic                hpd_rise,
    output logic                hpd_fall,
    output logic                rxs_rise,
    output logic                rxs_fall
);
    logic      [NUM_CH-1:0] raw_vec;
    chan_cfg_t              cfg_vec [NUM_CH];
    chan_out_t              out_vec [NUM_CH];

    assign raw_vec[CH_HPD]        = hpd_raw;
    assign raw_vec[CH_RXS]        = rxs_raw;
    assign cfg_vec[CH_HPD].glitch = hpd_glitch_w;
    assign cfg_vec[CH_HPD].valid  = hpd_valid_w;
    assign cfg_vec[CH_RXS].glitch = rxs_glitch_w;
    assign cfg_vec[CH_RXS].valid  = rxs_valid_w;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dgf_channel u_chan (
            .clk (clk),
            .rst (rst),
            .raw (raw_vec[ch]),
            .cfg (cfg_vec[ch]),
            .out (out_vec[ch])
        );
        assign filt_status[ch] = out_vec[ch].level;
    end

    assign hpd_rise = out_vec[CH_HPD].rise;
    assign hpd_fall = out_vec[CH_HPD].fall;
    assign rxs_rise = out_vec[CH_RXS].rise;
    assign rxs_fall = out_vec[CH_RXS].fall;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (filt_status == '0 && !hpd_rise && !rxs_rise)) else $error("reset state"); // R1
    AST_STATUS_EVENTS: assert property (@(posedge clk) disable iff (rst)
        hpd_rise |-> filt_status[CH_HPD]) else $error("status bit 0 mismatch"); // R9
endmodule

// File: tb/sim_presence_deglitch.sv
module sim_presence_deglitch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hpd_raw = 1'b0, rxs_raw = 1'b0;
    logic [3:0]  hpd_glitch_w = '0, rxs_glitch_w = '0;
    logic [11:0] hpd_valid_w = '0, rxs_valid_w = '0;
    logic [1:0]  filt_status;
    logic        hpd_rise, hpd_fall, rxs_rise, rxs_fall;

    int checks = 0, fails = 0;
    int n_hr = 0, n_hf = 0, n_rr = 0, n_rf = 0;

    always #4 clk = ~clk;

    presence_deglitch u0 (
        .clk(clk), .rst(rst), .hpd_raw(hpd_raw), .rxs_raw(rxs_raw),
        .hpd_glitch_w(hpd_glitch_w), .hpd_valid_w(hpd_valid_w),
        .rxs_glitch_w(rxs_glitch_w), .rxs_valid_w(rxs_valid_w),
        .filt_status(filt_status), .hpd_rise(hpd_rise), .hpd_fall(hpd_fall),
        .rxs_rise(rxs_rise), .rxs_fall(rxs_fall)
    );

    always @(negedge clk) if (!rst) begin
        if (hpd_rise) n_hr++;
        if (hpd_fall) n_hf++;
        if (rxs_rise) n_rr++;
        if (rxs_fall) n_rf++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // hpd_g, hpd_v, rxs_g, rxs_v, pulse length, hpd accepted, rxs accepted
    localparam int NV = 9;
    localparam int VEC [NV][7] = '{
        '{0, 0, 0, 0, 1,    1, 1},
        '{3, 0, 7, 0, 3,    0, 0},
        '{3, 0, 7, 0, 4,    1, 0},
        '{3, 0, 7, 0, 8,    1, 1},
        '{15, 0, 0, 0, 15,  0, 1},
        '{15, 0, 0, 0, 16,  1, 1},
        '{0, 1, 0, 0, 1024, 0, 1},
        '{0, 1, 0, 2, 1025, 1, 0},
        '{0, 2, 0, 1, 2049, 1, 1}
    };

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int b_hr, b_hf, b_rr, b_rf;
        settle(4);
        chk("R1 status in reset", filt_status, 0);
        chk("R1 events in reset", {hpd_rise, hpd_fall, rxs_rise, rxs_fall}, 0);
        @(negedge clk); rst = 1'b0;
        settle(1);
        chk("R1 status after reset", filt_status, 0);
        chk("R1 events after reset", {hpd_rise, hpd_fall, rxs_rise, rxs_fall}, 0);

        for (int i = 0; i < NV; i++) begin
            hpd_glitch_w = 4'(VEC[i][0]); hpd_valid_w = 12'(VEC[i][1]);
            rxs_glitch_w = 4'(VEC[i][2]); rxs_valid_w = 12'(VEC[i][3]);
            settle(4);
            b_hr = n_hr; b_hf = n_hf; b_rr = n_rr; b_rf = n_rf;
            hpd_raw = 1'b1; rxs_raw = 1'b1;
            repeat (VEC[i][4]) @(negedge clk);
            hpd_raw = 1'b0; rxs_raw = 1'b0;
            settle(4200);
            chk($sformatf("R3 R4 R8 vec%0d hpd rise count", i), n_hr - b_hr, VEC[i][5]);
            chk($sformatf("R7 vec%0d hpd fall count", i), n_hf - b_hf, VEC[i][5]);
            chk($sformatf("R3 R4 R8 vec%0d rxs rise count", i), n_rr - b_rr, VEC[i][6]);
            chk($sformatf("R7 vec%0d rxs fall count", i), n_rf - b_rf, VEC[i][6]);
            chk($sformatf("R9 vec%0d status idle", i), filt_status, 0);
        end

        // R2 latency with N=3, M=0: change at edge 7
        hpd_glitch_w = 4'd3; hpd_valid_w = '0;
        rxs_glitch_w = 4'd0; rxs_valid_w = '0;
        settle(4);
        hpd_raw = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk); #1;
            if (k == 6) chk("R2 hpd not yet at edge 6", filt_status[0], 0);
            if (k == 7) begin
                chk("R2 hpd at edge 7", filt_status[0], 1);
                chk("R6 rise on change cycle", hpd_rise, 1);
            end
        end
        @(posedge clk); #1;
        chk("R6 rise one cycle only", hpd_rise, 0);
        chk("R9 hpd on bit 0", filt_status, 1);
        @(negedge clk); rxs_raw = 1'b1;
        settle(10);
        chk("R9 rxs on bit 1", filt_status, 3);
        @(negedge clk); hpd_raw = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk); #1;
            if (k == 6) chk("R2 hpd fall not yet", filt_status[0], 1);
            if (k == 7) chk("R7 fall on change cycle", hpd_fall, 1);
        end
        @(posedge clk); #1;
        chk("R7 fall one cycle only", hpd_fall, 0);
        chk("R8 rxs unaffected by hpd", filt_status, 2);
        @(negedge clk); rxs_raw = 1'b0;
        settle(10);

        // R5 restart in glitch stage: 5 high, 1 low, 5 high with N=5
        hpd_glitch_w = 4'd5;
        settle(4);
        b_hr = n_hr;
        hpd_raw = 1'b1; repeat (5) @(negedge clk);
        hpd_raw = 1'b0; @(negedge clk);
        hpd_raw = 1'b1; repeat (5) @(negedge clk);
        hpd_raw = 1'b0;
        settle(40);
        chk("R5 glitch count restarts", n_hr - b_hr, 0);

        // R5 restart in stability stage: 1000 high, 2 low, 1000 high with M=1
        hpd_glitch_w = 4'd0; hpd_valid_w = 12'd1;
        settle(4);
        b_hr = n_hr;
        hpd_raw = 1'b1; repeat (1000) @(negedge clk);
        hpd_raw = 1'b0; repeat (2) @(negedge clk);
        hpd_raw = 1'b1; repeat (1000) @(negedge clk);
        hpd_raw = 1'b0;
        settle(1100);
        chk("R5 stability count restarts", n_hr - b_hr, 0);
        chk("R5 status stays low", filt_status, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule